// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of a byte-wide NAND flash bus and carries out one page-program transaction for each accepted request. A request gives a column byte, a 16-bit row, a byte count and a completion mode. The sequencer first writes the load command. It then sends three address bytes and moves the requested number of bytes from a streaming source onto the bus. It closes the load with the confirm command, waits for the array to finish and reports the outcome through a one-cycle done pulse.

Every bus write is a fixed pulse: the write strobe is held low for `STROBE_CYC` clocks and then high for `HOLD_CYC` clocks. Command, address and data are held stable for the whole step. A status read has the same shape on the read strobe. Completion can be detected in two ways. In ready-line mode the sequencer waits for the ready/busy line and then reads status once. In polling mode it issues the status command and re-reads status until the ready bit is set. A busy timer bounds both waits.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset the write and read strobes are high, the command and address latch enables are low, the bus is not driven, done is low and `req_ready` is high.
- R2: A request with `req_len` equal to 0 or greater than `PAGE_BYTES` (528) produces done with code 3 (rejected) on the clock edge that accepts it. No write strobe takes place.
- R3: An accepted request first writes 80h with the command latch enable high. It then writes three address bytes with the address latch enable high, in this order: `req_col`, `req_row[7:0]`, `req_row[15:8]`.
- R4: Exactly `req_len` data bytes follow, in stream order, with both latch enables low. Stalls on the stream only delay them.
- R5: The confirm command 10h is written directly after the last data byte, and never before at least one data byte has been written.
- R6: From the confirm command until done, the only bus write is a single status command 70h.
- R7: In ready-line mode (`req_poll`=0) the 70h write waits until `nf_rb` is high, and status is then read exactly once. Done code is 0 (pass) when status bit 0 is 0, and 1 (fail) when it is 1.
- R8: In polling mode (`req_poll`=1) 70h is written right after 10h, and status is re-read until bit 6 is 1. The result is then taken from bit 0 with the same codes.
- R9: If ready does not arrive within `TIMEOUT_CYC` cycles after the confirm command, done carries code 2 (timeout).
- R10: Each write strobe is low for exactly `STROBE_CYC` cycles. The write and read strobes are never low together, and the two latch enables are never high together.
- R11: `req_ready` is high only while idle, and done is high for exactly one cycle, after which a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_col | input | 8 | Start column (first address byte) |
| req_row | input | 16 | Page row (second and third address bytes) |
| req_len | input | LEN_W | Number of bytes to load |
| req_poll | input | 1 | 1: poll status bit 6, 0: wait on ready line |
| din_valid | input | 1 | Stream byte valid |
| din_ready | output | 1 | Sequencer takes a stream byte |
| din_data | input | 8 | Stream byte |
| done_valid | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 pass, 1 fail, 2 timeout, 3 rejected |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_out | output | 8 | Bus value driven |
| nf_dq_in | input | 8 | Bus value read |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
A rejected request raises done on the very edge that accepts it. The bench therefore samples done at the falling edge right after the request is dropped and requires that zero extra cycles have passed. Every bus byte is captured by the responder on the rising edge of the write strobe, so the checks compare the order and content of the recorded stream and never depend on a particular cycle for each byte. The status command write is timestamped against the confirm write and must come no earlier than the responder's busy time in ready-line mode. A timeout must arrive between `TIMEOUT_CYC` and `TIMEOUT_CYC` plus two bus steps and a few cycles after the confirm write.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CMD80, S_ADDR, S_FETCH, S_DATA, S_CMD10, S_WAITRB, S_CMD70, S_READ
  } nps_state_t;

  typedef enum logic [1:0] {
    D_PASS = 2'd0, D_FAIL = 2'd1, D_TIMEOUT = 2'd2, D_REJECT = 2'd3
  } nps_done_t;

  localparam logic [7:0] CMD_LOAD    = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;

  function automatic logic is_write_step(nps_state_t s);
    return (s == S_CMD80) || (s == S_ADDR) || (s == S_DATA) ||
           (s == S_CMD10) || (s == S_CMD70);
  endfunction
endpackage

// File: rtl/nps_req_check.sv
module nps_req_check #(
  parameter int PAGE_BYTES = 528,
  parameter int LEN_W      = 11
) (
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(PAGE_BYTES);
  assign ok = (len != '0) && (len <= MAX_LEN);
endmodule

// File: rtl/nps_busy_timer.sv
module nps_busy_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && cnt != LIM)
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq import nps_pkg::*; #(
  parameter int PAGE_BYTES  = 528,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int TIMEOUT_CYC = 100000,
  localparam int LEN_W      = $clog2(PAGE_BYTES + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_col,
  input  logic [15:0]      req_row,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_poll,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  output logic             done_valid,
  output logic [1:0]       done_code,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic             nf_dq_oe,
  output logic [7:0]       nf_dq_out,
  input  logic [7:0]       nf_dq_in,
  input  logic             nf_rb
);
  localparam int STEP = STROBE_CYC + HOLD_CYC;
  localparam int PH_W = $clog2(STEP + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP - 1);
  localparam logic [PH_W-1:0] PH_SAMP = PH_W'(STROBE_CYC - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(STROBE_CYC);

  nps_state_t       st, st_n;
  logic [PH_W-1:0]  ph, ph_n;
  logic [LEN_W-1:0] cnt, cnt_n;
  logic [1:0]       aidx, aidx_n;
  logic [7:0]       dq_n;
  logic [7:0]       col_q, stat_q;
  logic [15:0]      row_q;
  logic             poll_q;
  logic             dv_n;
  logic [1:0]       dc_n;
  logic             req_ok, t_exp, t_clr, t_en, step_st, step_last;

  nps_req_check #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) chk_i (
    .len(req_len), .ok(req_ok));

  assign t_clr = (st == S_CMD10);
  assign t_en  = (st == S_WAITRB) || (st == S_CMD70) || (st == S_READ);

  nps_busy_timer #(.LIMIT(TIMEOUT_CYC)) tmr_i (
    .clk(clk), .rst(rst), .clr(t_clr), .en(t_en), .expired(t_exp));

  assign req_ready = (st == S_IDLE);
  assign din_ready = (st == S_FETCH);
  assign step_st   = is_write_step(st) || (st == S_READ);
  assign step_last = step_st && (ph == PH_LAST);

  always_comb begin
    st_n   = st;
    ph_n   = (step_st && !step_last) ? ph + 1'b1 : '0;
    cnt_n  = cnt;
    aidx_n = aidx;
    dq_n   = nf_dq_out;
    dv_n   = 1'b0;
    dc_n   = done_code;
    case (st)
      S_IDLE: if (req_valid) begin
        if (!req_ok) begin
          dv_n = 1'b1;
          dc_n = D_REJECT;
        end else begin
          st_n  = S_CMD80;
          dq_n  = CMD_LOAD;
          cnt_n = req_len;
        end
      end
      S_CMD80: if (step_last) begin
        st_n   = S_ADDR;
        aidx_n = 2'd0;
        dq_n   = col_q;
      end
      S_ADDR: if (step_last) begin
        if (aidx == 2'd2) st_n = S_FETCH;
        else begin
          aidx_n = aidx + 2'd1;
          dq_n   = (aidx == 2'd0) ? row_q[7:0] : row_q[15:8];
        end
      end
      S_FETCH: if (din_valid) begin
        st_n = S_DATA;
        dq_n = din_data;
      end
      S_DATA: if (step_last) begin
        cnt_n = cnt - 1'b1;
        if (cnt == LEN_W'(1)) begin
          st_n = S_CMD10;
          dq_n = CMD_CONFIRM;
        end else st_n = S_FETCH;
      end
      S_CMD10: if (step_last) begin
        if (poll_q) begin
          st_n = S_CMD70;
          dq_n = CMD_STATUS;
        end else st_n = S_WAITRB;
      end
      S_WAITRB: begin
        if (t_exp) begin
          st_n = S_IDLE; dv_n = 1'b1; dc_n = D_TIMEOUT;
        end else if (nf_rb) begin
          st_n = S_CMD70;
          dq_n = CMD_STATUS;
        end
      end
      S_CMD70: if (step_last) st_n = S_READ;
      S_READ: if (step_last) begin
        if (!poll_q || stat_q[6]) begin
          st_n = S_IDLE; dv_n = 1'b1;
          dc_n = stat_q[0] ? D_FAIL : D_PASS;
        end else if (t_exp) begin
          st_n = S_IDLE; dv_n = 1'b1; dc_n = D_TIMEOUT;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ph         <= '0;
      cnt        <= '0;
      aidx       <= '0;
      done_valid <= 1'b0;
      done_code  <= D_PASS;
      nf_we_n    <= 1'b1;
      nf_re_n    <= 1'b1;
      nf_cle     <= 1'b0;
      nf_ale     <= 1'b0;
      nf_dq_oe   <= 1'b0;
      nf_dq_out  <= '0;
    end else begin
      st         <= st_n;
      ph         <= ph_n;
      cnt        <= cnt_n;
      aidx       <= aidx_n;
      done_valid <= dv_n;
      done_code  <= dc_n;
      nf_we_n    <= !(is_write_step(st_n) && ph_n < PH_HIGH);
      nf_re_n    <= !((st_n == S_READ) && ph_n < PH_HIGH);
      nf_cle     <= (st_n == S_CMD80) || (st_n == S_CMD10) || (st_n == S_CMD70);
      nf_ale     <= (st_n == S_ADDR);
      nf_dq_oe   <= is_write_step(st_n);
      nf_dq_out  <= dq_n;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && req_valid && req_ok) begin
      col_q  <= req_col;
      row_q  <= req_row;
      poll_q <= req_poll;
    end
    if (st == S_READ && ph == PH_SAMP)
      stat_q <= nf_dq_in;
  end

  // Data bytes written since acceptance, kept apart from the load counter.
  logic [LEN_W-1:0] sent_q;
  always_ff @(posedge clk) begin
    if (rst || (st == S_IDLE)) sent_q <= '0;
    else if (st == S_DATA && step_last) sent_q <= sent_q + 1'b1;
  end

  p_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && req_valid && !req_ok) |=>
      (done_valid && done_code == D_REJECT && nf_we_n && st == S_IDLE));

  p_confirm_after_data_r5: assert property (@(posedge clk) disable iff (rst)
    (!nf_we_n && nf_cle && nf_dq_out == CMD_CONFIRM) |-> (sent_q != '0));

  p_busy_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (t_en && !nf_we_n) |-> (nf_cle && nf_dq_out == CMD_STATUS));

  p_timeout_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAITRB && t_exp) |=> (done_valid && done_code == D_TIMEOUT));

  p_latch_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(!nf_we_n && !nf_re_n));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  p_ready_at_done_r11: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> req_ready);
endmodule

// File: tb/nand_prog_seq_tb_top.sv
module nand_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 528;
  localparam int TO = 300;
  localparam int SC = 2;
  localparam int HC = 1;
  localparam int LW = $clog2(PB + 1) + 1;

  logic clk = 1'b0;
  logic rst;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          req_valid, req_ready, req_poll;
  logic [7:0]    req_col;
  logic [15:0]   req_row;
  logic [LW-1:0] req_len;
  logic          din_valid, din_ready;
  logic [7:0]    din_data;
  logic          done_valid;
  logic [1:0]    done_code;
  logic          nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_rb;
  logic [7:0]    nf_dq_out, nf_dq_in;

  nand_prog_seq #(.PAGE_BYTES(PB), .STROBE_CYC(SC), .HOLD_CYC(HC), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_col(req_col), .req_row(req_row), .req_len(req_len), .req_poll(req_poll),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .done_valid(done_valid), .done_code(done_code),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_oe(nf_dq_oe), .nf_dq_out(nf_dq_out), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 13 + 5) ^ s;
  endfunction

  // Responder and bus recorder
  logic clr_log = 1'b0;
  logic fail_flag = 1'b0;
  int   busy_cycles = 40;
  logic rdy;
  int   busy_left, nlog, nreads, cyc, confirm_cyc, status_cyc;
  logic we_prev, re_prev;
  int   lg_kind [0:1023];
  int   lg_val  [0:1023];

  assign nf_rb    = rdy;
  assign nf_dq_in = {1'b0, rdy, 5'b0, fail_flag};

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    we_prev <= nf_we_n;
    re_prev <= nf_re_n;
    if (rst || clr_log) begin
      rdy <= 1'b1; busy_left <= 0; nlog <= 0; nreads <= 0;
      confirm_cyc <= 0; status_cyc <= 0;
    end else begin
      if (!we_prev && nf_we_n) begin
        if (nlog < 1024) begin
          lg_kind[nlog] <= nf_cle ? 0 : (nf_ale ? 1 : 2);
          lg_val[nlog]  <= int'(nf_dq_out);
        end
        nlog <= nlog + 1;
        if (nf_cle && nf_dq_out == 8'h10) begin
          rdy <= 1'b0; busy_left <= busy_cycles; confirm_cyc <= cyc;
        end
        if (nf_cle && nf_dq_out == 8'h70) status_cyc <= cyc;
      end else if (!rdy) begin
        if (busy_left <= 1) rdy <= 1'b1;
        else busy_left <= busy_left - 1;
      end
      if (!re_prev && nf_re_n) nreads <= nreads + 1;
    end
  end

  // Stream source
  int         src_idx, src_len = 0, gate;
  logic       stall_b = 1'b0;
  logic [7:0] seed = 8'h00;
  always @(posedge clk) begin
    gate <= gate + 1;
    if (rst || clr_log) src_idx <= 0;
    else if (din_valid && din_ready) src_idx <= src_idx + 1;
  end
  assign din_valid = (src_idx < src_len) && !(stall_b && (gate % 3 == 0));
  assign din_data  = pat(src_idx, seed);

  task automatic run(input int len, input bit poll, input bit fl, input int busy,
                     input bit stall, input int exp_code);
    int w, code, bad, dcyc;
    logic [7:0]  col;
    logic [15:0] row;
    col = 8'(len * 3 + 1);
    row = {8'(len) ^ 8'hA5, 8'h3C + 8'(poll)};
    @(negedge clk);
    clr_log = 1'b1; fail_flag = fl; busy_cycles = busy; stall_b = stall;
    seed = 8'(len + 17);
    src_len = (exp_code == 3) ? 0 : len;
    @(negedge clk);
    clr_log = 1'b0;
    req_valid = 1'b1; req_col = col; req_row = row; req_len = LW'(len); req_poll = poll;
    chk(req_ready == 1'b1, "R11 ready while idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done_valid && w < 20000) begin @(negedge clk); w++; end
    chk(done_valid == 1'b1, "R11 done seen", int'(done_valid), 1);
    code = int'(done_code);
    dcyc = cyc;
    chk(code == exp_code, "R7 R8 R9 R2 done code", code, exp_code);
    @(negedge clk);
    chk(done_valid == 1'b0, "R11 done one cycle", int'(done_valid), 0);
    if (exp_code == 3) begin
      chk(w == 0, "R2 reject latency", w, 0);
      chk(nlog == 0, "R2 no bus writes", nlog, 0);
      return;
    end
    chk(lg_kind[0] == 0 && lg_val[0] == 8'h80, "R3 load command", lg_val[0], 8'h80);
    chk(lg_kind[1] == 1 && lg_val[1] == int'(col), "R3 addr col", lg_val[1], int'(col));
    chk(lg_kind[2] == 1 && lg_val[2] == int'(row[7:0]), "R3 addr row lo", lg_val[2], int'(row[7:0]));
    chk(lg_kind[3] == 1 && lg_val[3] == int'(row[15:8]), "R3 addr row hi", lg_val[3], int'(row[15:8]));
    bad = 0;
    for (int i = 0; i < len; i++)
      if (lg_kind[4 + i] != 2 || lg_val[4 + i] != int'(pat(i, seed))) bad++;
    chk(bad == 0, "R4 data bytes mismatching", bad, 0);
    chk(lg_kind[4 + len] == 0 && lg_val[4 + len] == 8'h10, "R5 confirm after data",
        lg_val[4 + len], 8'h10);
    if (exp_code == 2) begin
      chk(dcyc - confirm_cyc >= TO && dcyc - confirm_cyc <= TO + 2 * (SC + HC) + 6,
          "R9 timeout window", dcyc - confirm_cyc, TO);
      chk(nlog == len + (poll ? 6 : 5), "R6 writes under timeout", nlog, len + (poll ? 6 : 5));
      return;
    end
    chk(nlog == len + 6, "R6 single status write", nlog, len + 6);
    chk(lg_kind[5 + len] == 0 && lg_val[5 + len] == 8'h70, "R6 status command",
        lg_val[5 + len], 8'h70);
    if (poll) begin
      chk(nreads >= 2, "R8 status polled repeatedly", nreads, 2);
    end else begin
      chk(nreads == 1, "R7 single status read", nreads, 1);
      chk(status_cyc - confirm_cyc >= busy, "R7 waits for ready line",
          status_cyc - confirm_cyc, busy);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // R10: write strobe low-run length
  int lo_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!nf_we_n) lo_run <= lo_run + 1;
      else if (lo_run != 0) begin
        chk(lo_run == SC, "R10 write strobe width", lo_run, SC);
        lo_run <= 0;
      end
    end
  end

  initial begin
    int lens [6] = '{1, 2, 3, 7, 64, 528};
    req_valid = 1'b0; req_col = '0; req_row = '0; req_len = '0; req_poll = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe && !done_valid && req_ready,
        "R1 reset state", {nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe, done_valid, req_ready}, 7'b1100001);
    rst = 1'b0;
    run(0, 1'b0, 1'b0, 40, 1'b0, 3);
    run(529, 1'b1, 1'b0, 40, 1'b0, 3);
    run(1023, 1'b0, 1'b0, 40, 1'b0, 3);
    foreach (lens[k])
      for (int m = 0; m < 4; m++)
        run(lens[k], m[0], m[1], 40 + 7 * k, k[0] ^ m[0], m[1] ? 1 : 0);
    run(5, 1'b0, 1'b0, 1000000, 1'b0, 2);
    run(4, 1'b1, 1'b1, 1000000, 1'b1, 2);
    run(528, 1'b1, 1'b0, 5, 1'b1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule